// File: doc/BRIEF.md
# Coded Reference Divider

This block divides a reference clock down to the comparison rate of a frequency synthesiser. A 5-bit ratio code selects the division. The upper two code bits pick a base factor of 2, 5, 6 or 7. The lower three bits pick a power-of-two multiplier. This gives 29 usable ratios between 2 and 448. The remaining three codes are rejected: a flag is raised and the divider keeps counting at its last accepted ratio.

A new ratio never cuts a period short. The divider finishes the period in progress at the old ratio and starts counting at the new ratio only after that period ends. The comparison output is a single reference-clock-wide pulse at the end of every period.

A 3-bit test mode drives a shared test port. The port can reflect a plain programmed bit, an externally supplied half-rate feedback-divider signal, or the comparison pulse. All pins are plain control and status pins. There is no streaming data path, so no valid/ready handshake applies.

Top module: `ref_div_top`

## Requirements
- R1: While rst_n is low, cmp_pulse and code_bad are 0. After reset the ratio is 2, so the first cmp_pulse appears 2 clocks after rst_n rises.
- R2: For codes with bits [4:3] = 00 and low bits k = bits [2:0], the period between cmp_pulse assertions is 2^(k+1) clocks (2 to 256).
- R3: For codes with bits [4:3] = 01, 10 or 11 and k = 1..7, the period is B*2^(k-1) clocks, where B is 5, 6 or 7 respectively.
- R4: Codes 01000, 10000 and 11000 are illegal. code_bad is 1 exactly one clock after such a code is presented and 0 one clock after a legal code. While the code is illegal, the period stays at the last legal ratio.
- R5: cmp_pulse is high for exactly one clock per period.
- R6: A ratio change takes effect only at a period boundary. The period running when the code changes completes at the old ratio, and the following period uses the new ratio.
- R7: When test_mode[2] = 0, port_out equals port_bit and port_oe equals port_bit. A value of 0 means the port is off (high impedance).
- R8: When test_mode = 100, port_out equals fb_half and port_oe is 1.
- R9: When test_mode is 101, 110 or 111, port_out equals cmp_pulse and port_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_code | input | 5 | Division ratio selection code |
| test_mode | input | 3 | Test-port source selection |
| port_bit | input | 1 | Programmed general-purpose port state |
| fb_half | input | 1 | Feedback divider output already halved |
| cmp_pulse | output | 1 | One-clock comparison pulse per period |
| code_bad | output | 1 | Registered illegal-code flag |
| port_out | output | 1 | Test/general-purpose port value |
| port_oe | output | 1 | Port drive enable (0 = high impedance) |

## Verification
code_bad is registered, so it is due one clock after a code is driven. The bench drives codes on a falling edge and samples code_bad at the next falling edge.

A new ratio is registered one edge after it is driven. It is then loaded at the next period boundary, so the bench discards one full period before it measures the new one. The period is measured as the count of falling edges between successive cmp_pulse samples.

The port multiplexer is combinational, so port checks sample at the same falling edge at which the inputs were changed. For the boundary test, the code changes ten clocks into a 256-clock period. The bench then expects exactly 256 clocks before the next pulse, followed by a period of 2.

// File: rtl/ref_div_pkg.sv
package ref_div_pkg;

  parameter int unsigned CODE_W  = 5;
  parameter int unsigned TMODE_W = 3;
  parameter int unsigned RATIO_W = 9;

  typedef enum logic [1:0] {
    SEL_BIT = 2'd0,
    SEL_FB  = 2'd1,
    SEL_CMP = 2'd2
  } port_sel_e;

endpackage

// File: rtl/ref_div_decode.sv
module ref_div_decode
  import ref_div_pkg::*;
#(
  parameter int unsigned CNT_W = RATIO_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  ratio,
  output logic              legal
);

  localparam int unsigned EXP_W = 3;

  logic [1:0]       grp;
  logic [EXP_W-1:0] k;
  logic [CNT_W-1:0] base;

  assign grp = code[CODE_W-1 -: 2];
  assign k   = code[EXP_W-1:0];

  always_comb begin
    legal = (grp == 2'b00) || (k != '0);
    base  = CNT_W'(4) + CNT_W'(grp);
    if (grp == 2'b00)
      ratio = CNT_W'(2) << k;
    else if (k == '0)
      ratio = '0;
    else
      ratio = base << (k - EXP_W'(1));
  end

endmodule

// File: rtl/ref_div_counter.sv
module ref_div_counter
  import ref_div_pkg::*;
#(
  parameter int unsigned CNT_W = RATIO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] new_ratio,
  input  logic             new_ok,
  output logic             pulse,
  output logic             bad,
  output logic [CNT_W-1:0] act_ratio
);

  localparam logic [CNT_W-1:0] RST_RATIO = CNT_W'(2);

  logic [CNT_W-1:0] pend_q;
  logic [CNT_W-1:0] act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap      = (cnt_q == act_q - CNT_W'(1));
  assign act_ratio = act_q;

  // Accepted ratio waits here until the running period closes.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= RST_RATIO;
      bad    <= 1'b0;
    end else begin
      bad <= !new_ok;
      if (new_ok)
        pend_q <= new_ratio;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= RST_RATIO;
      pulse <= 1'b0;
    end else begin
      pulse <= wrap;
      if (wrap) begin
        cnt_q <= '0;
        act_q <= pend_q;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/ref_div_portmux.sv
module ref_div_portmux
  import ref_div_pkg::*;
(
  input  logic [TMODE_W-1:0] tmode,
  input  logic               port_bit,
  input  logic               fb_half,
  input  logic               cmp,
  output logic               port_out,
  output logic               port_oe
);

  port_sel_e sel;

  always_comb begin
    if (!tmode[TMODE_W-1])
      sel = SEL_BIT;
    else if (tmode[TMODE_W-2:0] == '0)
      sel = SEL_FB;
    else
      sel = SEL_CMP;
  end

  always_comb begin
    unique case (sel)
      SEL_FB: begin
        port_out = fb_half;
        port_oe  = 1'b1;
      end
      SEL_CMP: begin
        port_out = cmp;
        port_oe  = 1'b1;
      end
      default: begin
        port_out = port_bit;
        port_oe  = port_bit;
      end
    endcase
  end

endmodule

// File: rtl/ref_div_top.sv
module ref_div_top
  import ref_div_pkg::*;
#(
  parameter int unsigned CNT_W = RATIO_W
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic [CODE_W-1:0]  ratio_code,
  input  logic [TMODE_W-1:0] test_mode,
  input  logic               port_bit,
  input  logic               fb_half,
  output logic               cmp_pulse,
  output logic               code_bad,
  output logic               port_out,
  output logic               port_oe
);

  logic [CNT_W-1:0] dec_ratio;
  logic             dec_ok;
  logic [CNT_W-1:0] act_ratio;

  ref_div_decode #(.CNT_W(CNT_W)) u_dec (
    .code  (ratio_code),
    .ratio (dec_ratio),
    .legal (dec_ok)
  );

  ref_div_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (ref_clk),
    .rst_n     (rst_n),
    .new_ratio (dec_ratio),
    .new_ok    (dec_ok),
    .pulse     (cmp_pulse),
    .bad       (code_bad),
    .act_ratio (act_ratio)
  );

  ref_div_portmux u_mux (
    .tmode    (test_mode),
    .port_bit (port_bit),
    .fb_half  (fb_half),
    .cmp      (cmp_pulse),
    .port_out (port_out),
    .port_oe  (port_oe)
  );

endmodule

// File: rtl/ref_div_chk.sv
module ref_div_chk
  import ref_div_pkg::*;
#(
  parameter int unsigned CNT_W = RATIO_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CODE_W-1:0]  code,
  input logic [TMODE_W-1:0] tmode,
  input logic               port_bit,
  input logic               fb_half,
  input logic               cmp_pulse,
  input logic               code_bad,
  input logic               port_out,
  input logic               port_oe,
  input logic [CNT_W-1:0]   act_ratio
);

  logic code_ill;
  assign code_ill = (code[2:0] == 3'b000) && (code[4:3] != 2'b00);

  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(code_ill)) |-> code_bad);

  a_r4_flag_clr: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(code_ill)) |-> !code_bad);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |=> !cmp_pulse);

  a_r6_change_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_ratio) |-> cmp_pulse);

  a_r7_port_plain: assert property (@(posedge clk) disable iff (!rst_n)
    !tmode[2] |-> (port_out == port_bit && port_oe == port_bit));

  a_r8_port_fb: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode == 3'b100) |-> (port_out == fb_half && port_oe));

  a_r9_port_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode[2] && tmode[1:0] != 2'b00) |-> (port_out == cmp_pulse && port_oe));

endmodule

bind ref_div_top ref_div_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (ref_clk),
  .rst_n     (rst_n),
  .code      (ratio_code),
  .tmode     (test_mode),
  .port_bit  (port_bit),
  .fb_half   (fb_half),
  .cmp_pulse (cmp_pulse),
  .code_bad  (code_bad),
  .port_out  (port_out),
  .port_oe   (port_oe),
  .act_ratio (act_ratio)
);

// File: tb/tb_ref_div_top.sv
module tb_ref_div_top;

  logic       ref_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] ratio_code = 5'd0;
  logic [2:0] test_mode = 3'd0;
  logic       port_bit = 1'b0;
  logic       fb_half = 1'b0;
  logic       cmp_pulse, code_bad, port_out, port_oe;

  int n_run = 0;
  int n_fail = 0;

  always #5 ref_clk = ~ref_clk;

  ref_div_top dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .ratio_code(ratio_code),
    .test_mode(test_mode), .port_bit(port_bit), .fb_half(fb_half),
    .cmp_pulse(cmp_pulse), .code_bad(code_bad),
    .port_out(port_out), .port_oe(port_oe)
  );

  // {code, expected period, expected flag}; illegal rows keep the prior ratio
  typedef struct packed { logic [4:0] code; logic [8:0] per; logic bad; } vec_t;
  localparam vec_t VECS [32] = '{
    '{5'b00000, 9'd2,   1'b0}, '{5'b00001, 9'd4,   1'b0},
    '{5'b00010, 9'd8,   1'b0}, '{5'b00011, 9'd16,  1'b0},
    '{5'b00100, 9'd32,  1'b0}, '{5'b00101, 9'd64,  1'b0},
    '{5'b00110, 9'd128, 1'b0}, '{5'b00111, 9'd256, 1'b0},
    '{5'b01000, 9'd256, 1'b1}, '{5'b01001, 9'd5,   1'b0},
    '{5'b01010, 9'd10,  1'b0}, '{5'b01011, 9'd20,  1'b0},
    '{5'b01100, 9'd40,  1'b0}, '{5'b01101, 9'd80,  1'b0},
    '{5'b01110, 9'd160, 1'b0}, '{5'b01111, 9'd320, 1'b0},
    '{5'b10000, 9'd320, 1'b1}, '{5'b10001, 9'd6,   1'b0},
    '{5'b10010, 9'd12,  1'b0}, '{5'b10011, 9'd24,  1'b0},
    '{5'b10100, 9'd48,  1'b0}, '{5'b10101, 9'd96,  1'b0},
    '{5'b10110, 9'd192, 1'b0}, '{5'b10111, 9'd384, 1'b0},
    '{5'b11000, 9'd384, 1'b1}, '{5'b11001, 9'd7,   1'b0},
    '{5'b11010, 9'd14,  1'b0}, '{5'b11011, 9'd28,  1'b0},
    '{5'b11100, 9'd56,  1'b0}, '{5'b11101, 9'd112, 1'b0},
    '{5'b11110, 9'd224, 1'b0}, '{5'b11111, 9'd448, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic meas(output int n);
    while (!cmp_pulse) @(negedge ref_clk);
    n = 0;
    do begin
      @(negedge ref_clk);
      n++;
    end while (!cmp_pulse);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge ref_clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int n;
    int hi;
    // R1: reset state and first period
    repeat (3) @(negedge ref_clk);
    chk(cmp_pulse == 1'b0, "R1 pulse in reset", cmp_pulse, 0);
    chk(code_bad == 1'b0, "R1 flag in reset", code_bad, 0);
    rst_n = 1'b1;
    n = 0;
    do begin
      @(negedge ref_clk);
      n++;
    end while (!cmp_pulse && n < 20);
    chk(n == 2, "R1 first period", n, 2);

    // R2 R3 R4: table walk over every code
    for (int i = 0; i < 32; i++) begin
      ratio_code = VECS[i].code;
      @(negedge ref_clk);
      chk(code_bad == VECS[i].bad, $sformatf("R4 flag code %b", VECS[i].code),
          code_bad, VECS[i].bad);
      meas(n);
      meas(n);
      chk(n == int'(VECS[i].per),
          $sformatf("%s period code %b", (i < 8) ? "R2" : (VECS[i].bad ? "R4" : "R3"),
                    VECS[i].code), n, VECS[i].per);
    end

    // R6: change mid-period, old period must complete
    ratio_code = 5'b00111;
    meas(n);
    meas(n);
    n = 0;
    do begin
      @(negedge ref_clk);
      n++;
      if (n == 10) ratio_code = 5'b00000;
    end while (!cmp_pulse);
    chk(n == 256, "R6 old period completes", n, 256);
    meas(n);
    chk(n == 2, "R6 new period after boundary", n, 2);

    // R5: one-clock pulse
    meas(n);
    @(negedge ref_clk);
    chk(cmp_pulse == 1'b0, "R5 pulse width at ratio 2", cmp_pulse, 0);
    ratio_code = 5'b01001;
    meas(n);
    meas(n);
    hi = 0;
    for (int c = 0; c < 50; c++) begin
      @(negedge ref_clk);
      if (cmp_pulse) hi++;
    end
    chk(hi == 10, "R5 pulses in 50 clocks at ratio 5", hi, 10);

    // R7: plain port
    test_mode = 3'b000; port_bit = 1'b1; #1;
    chk(port_out && port_oe, "R7 port on", {port_out, port_oe}, 3);
    port_bit = 1'b0; #1;
    chk(!port_out && !port_oe, "R7 port off", {port_out, port_oe}, 0);
    test_mode = 3'b011; port_bit = 1'b1; fb_half = 1'b0; #1;
    chk(port_out && port_oe, "R7 mode 011 follows bit", {port_out, port_oe}, 3);

    // R8: half-rate feedback on port
    test_mode = 3'b100; port_bit = 1'b0; fb_half = 1'b1; #1;
    chk(port_out && port_oe, "R8 fb high", {port_out, port_oe}, 3);
    fb_half = 1'b0; #1;
    chk(!port_out && port_oe, "R8 fb low", {port_out, port_oe}, 1);

    // R9: comparison pulse on port
    test_mode = 3'b110;
    ratio_code = 5'b00000;
    meas(n);
    meas(n);
    hi = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge ref_clk);
      if (port_out && port_oe) hi++;
    end
    chk(hi == 10, "R9 port pulses in 20 clocks", hi, 10);
    test_mode = 3'b101;
    meas(n);
    chk(port_out && port_oe, "R9 mode 101 port at pulse", {port_out, port_oe}, 3);

    finish_run();
  end

endmodule